// File: doc/BRIEF.md
# Masked Bus Watchpoint Comparator

This block watches a processor's bus for debug purposes. It holds two independent comparator units. Each unit has a value and a mask register for the address bus, for the data bus and for a byte of bus-control signals. On every bus cycle marked valid, a unit reports a hit when all of its unmasked bits equal the live bus. The control byte carries the fetch/data flag and the write flag. A unit programmed for fetches therefore behaves as a breakpoint, and a unit programmed for data accesses behaves as a watchpoint with a read, write or either-direction qualifier. Setting the data mask below all-ones makes a data watchpoint data-dependent.

A qualifying hit produces a halt request one clock after the bus cycle. The same edge sets a sticky record of which unit fired. Software reaches the block through a small addressed register port that stands in for a serial scan path. The port holds a global control register, a status register, two comms storage registers and the twelve comparator registers.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset every mapped register reads zero, both units are disabled and halt_req is low.
- R2: The register port decodes 5-bit addresses:
  - 0x00 global control, 3 bits.
  - 0x01 status, 5 bits.
  - 0x04 comms control, 6 bits.
  - 0x05 comms data, 32 bits.
  - Unit 0 sits at 0x08..0x0D and unit 1 at 0x10..0x15. Each unit's registers are, in order: address value, address mask, data value, data mask (32 bits each), control value (9 bits) and control mask (8 bits).
  - Bits above a register's width read as zero.
- R3: Reads of any other address return zero, and writes to them change no register.
- R4: An enabled unit hits only when address, data and bus_ctrl equal its value registers in every bit whose mask bit is 0. A difference in any such bit prevents the halt.
- R5: A mask bit of 1 makes the corresponding bus bit a don't-care.
- R6: A unit is enabled by bit 8 of its control value. A disabled unit never hits. Global control bit 0 must be 1 for any halt or status update.
- R7: bus_ctrl bit 0 is 1 for an instruction fetch and 0 for a data access. With that bit unmasked, control value bit 0 chooses between breakpoint and data watchpoint behaviour.
- R8: bus_ctrl bit 1 is 1 for a write and 0 for a read. With that bit unmasked, control value bit 1 selects a write-only or read-only watch. With it masked, either direction matches.
- R9: halt_req rises on the clock edge that ends a qualifying cycle with bus_valid high, and stays high for exactly that one cycle. A cycle with bus_valid low never causes a halt.
- R10: Status bit 0 (unit 0) and bit 1 (unit 1) are set by the unit that fired and remain set until software writes 1 to that bit of the status register.
- R11: With global control bit 1 set, a halt needs both units to hit in the same cycle, and it then sets both status bits. With bit 1 clear, either unit alone halts and sets only its own status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| bus_valid | input | 1 | Bus cycle valid |
| bus_addr | input | ADDR_W | Live address bus |
| bus_data | input | DATA_W | Live data bus |
| bus_ctrl | input | 8 | Bus control: bit 0 fetch, bit 1 write, others user attributes |
| halt_req | output | 1 | Registered halt request |

## Verification
The bench builds the block with ADDR_W and DATA_W both at their default of 32. At that width every register in the map reaches its full stated width. All-ones writes can then show the truncation of the 9-bit and 8-bit control registers next to the full 32-bit address and data registers. Full width also lets partial address masks and a single-word data-dependent watch be tested on realistic bus values.

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [7:0]        bus_ctrl,
  output logic              halt_req
);

  localparam int NU = 2;
  localparam int CW = 8;

  logic [2:0]        dctl_q;
  logic [NU-1:0]     sticky_q;
  logic [5:0]        cctl_q;
  logic [31:0]       cdat_q;
  logic [ADDR_W-1:0] av_q [NU];
  logic [ADDR_W-1:0] am_q [NU];
  logic [DATA_W-1:0] dv_q [NU];
  logic [DATA_W-1:0] dm_q [NU];
  logic [CW:0]       cv_q [NU];
  logic [CW-1:0]     cm_q [NU];

  logic [NU-1:0] hit;

  generate
    for (genvar g = 0; g < NU; g++) begin : g_unit
      wire a_ok = ((bus_addr ^ av_q[g]) & ~am_q[g]) == '0;
      wire d_ok = ((bus_data ^ dv_q[g]) & ~dm_q[g]) == '0;
      wire c_ok = ((bus_ctrl ^ cv_q[g][CW-1:0]) & ~cm_q[g]) == '0;
      assign hit[g] = cv_q[g][CW] & a_ok & d_ok & c_ok;
    end
  endgenerate

  wire           glob_en  = dctl_q[0];
  wire           combine  = dctl_q[1];
  wire           fire     = bus_valid & glob_en & (combine ? &hit : |hit);
  wire [NU-1:0]  set_bits = fire ? (combine ? {NU{1'b1}} : hit) : '0;
  wire           stat_wr  = reg_wr && reg_addr == 5'h01;
  wire [NU-1:0]  clr_bits = stat_wr ? reg_wdata[NU-1:0] : '0;

  wire       wp_sel = (reg_addr[4:3] == 2'b01 || reg_addr[4:3] == 2'b10) && reg_addr[2:0] < 3'd6;
  wire       wu     = reg_addr[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dctl_q   <= '0;
      sticky_q <= '0;
      cctl_q   <= '0;
      cdat_q   <= '0;
      halt_req <= 1'b0;
      for (int i = 0; i < NU; i++) begin
        av_q[i] <= '0;
        am_q[i] <= '0;
        dv_q[i] <= '0;
        dm_q[i] <= '0;
        cv_q[i] <= '0;
        cm_q[i] <= '0;
      end
    end else begin
      halt_req <= fire;
      sticky_q <= (sticky_q & ~clr_bits) | set_bits;
      if (reg_wr) begin
        case (reg_addr)
          5'h00: dctl_q <= reg_wdata[2:0];
          5'h04: cctl_q <= reg_wdata[5:0];
          5'h05: cdat_q <= reg_wdata;
          default: begin
            if (wp_sel) begin
              case (reg_addr[2:0])
                3'd0: av_q[wu] <= reg_wdata[ADDR_W-1:0];
                3'd1: am_q[wu] <= reg_wdata[ADDR_W-1:0];
                3'd2: dv_q[wu] <= reg_wdata[DATA_W-1:0];
                3'd3: dm_q[wu] <= reg_wdata[DATA_W-1:0];
                3'd4: cv_q[wu] <= reg_wdata[CW:0];
                default: cm_q[wu] <= reg_wdata[CW-1:0];
              endcase
            end
          end
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      5'h00: reg_rdata = 32'(dctl_q);
      5'h01: reg_rdata = 32'(sticky_q);
      5'h04: reg_rdata = 32'(cctl_q);
      5'h05: reg_rdata = cdat_q;
      default: begin
        if (wp_sel) begin
          case (reg_addr[2:0])
            3'd0: reg_rdata = 32'(av_q[wu]);
            3'd1: reg_rdata = 32'(am_q[wu]);
            3'd2: reg_rdata = 32'(dv_q[wu]);
            3'd3: reg_rdata = 32'(dm_q[wu]);
            3'd4: reg_rdata = 32'(cv_q[wu]);
            default: reg_rdata = 32'(cm_q[wu]);
          endcase
        end
      end
    endcase
  end

  // R9
  halt_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(bus_valid));

  // R6
  halt_needs_glob_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(dctl_q[0]));

  // R10
  halt_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> sticky_q != '0);

  // R10
  sticky_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky_q[0]) |-> $past(reg_wr && reg_addr == 5'h01 && reg_wdata[0]));

  // R11
  combine_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && $past(dctl_q[1])) |-> &sticky_q);

endmodule

// File: tb/tb_dbg_watch_unit.sv
module tb_dbg_watch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic [7:0]  bus_ctrl = '0;
  logic        halt_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dbg_watch_unit #(.ADDR_W(32), .DATA_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
    .halt_req(halt_req)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(string req, logic [4:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic prog(int u, logic [31:0] av, logic [31:0] am, logic [31:0] dv,
                      logic [31:0] dm, logic [31:0] cv, logic [31:0] cm);
    logic [4:0] b = (u == 0) ? 5'h08 : 5'h10;
    wr(b + 5'd0, av); wr(b + 5'd1, am); wr(b + 5'd2, dv);
    wr(b + 5'd3, dm); wr(b + 5'd4, cv); wr(b + 5'd5, cm);
  endtask

  task automatic bus(string req, logic [31:0] a, logic [31:0] d, logic [7:0] c, logic exp);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_data = d; bus_ctrl = c;
    @(negedge clk);
    bus_valid = 1'b0;
    check(req, 32'(halt_req), 32'(exp));
  endtask

  task automatic clr_status();
    wr(5'h01, 32'h3);
  endtask

  task automatic t_reset();
    check("R1 halt", 32'(halt_req), 32'h0);
    for (int i = 0; i < 32; i++) rd("R1", 5'(i), 32'h0);
  endtask

  task automatic t_regmap();
    logic [4:0]  adr [14] = '{5'h00,5'h01,5'h04,5'h05,5'h08,5'h09,5'h0A,5'h0B,5'h0C,5'h0D,
                             5'h10,5'h11,5'h12,5'h13};
    logic [31:0] msk [14] = '{32'h7,32'h0,32'h3F,32'hFFFFFFFF,32'hFFFFFFFF,32'hFFFFFFFF,
                             32'hFFFFFFFF,32'hFFFFFFFF,32'h1FF,32'hFF,
                             32'hFFFFFFFF,32'hFFFFFFFF,32'hFFFFFFFF,32'hFFFFFFFF};
    for (int i = 0; i < 14; i++) begin
      wr(adr[i], 32'hFFFFFFFF);
      rd("R2 width", adr[i], msk[i]);
      wr(adr[i], 32'h0);
    end
    wr(5'h14, 32'hFFFFFFFF); rd("R2 width u1 cv", 5'h14, 32'h1FF); wr(5'h14, 32'h0);
    wr(5'h15, 32'hFFFFFFFF); rd("R2 width u1 cm", 5'h15, 32'hFF); wr(5'h15, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [4:0] bad [7] = '{5'h02,5'h03,5'h06,5'h0E,5'h0F,5'h16,5'h1F};
    wr(5'h08, 32'h12345678);
    wr(5'h05, 32'hCAFEF00D);
    for (int i = 0; i < 7; i++) begin
      wr(bad[i], 32'hFFFFFFFF);
      rd("R3 unmapped read", bad[i], 32'h0);
    end
    rd("R3 no side effect", 5'h08, 32'h12345678);
    rd("R3 no side effect", 5'h05, 32'hCAFEF00D);
    rd("R3 no side effect", 5'h00, 32'h0);
    wr(5'h08, 32'h0); wr(5'h05, 32'h0);
  endtask

  task automatic t_fetch();
    wr(5'h00, 32'h1);
    prog(0, 32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h101, 32'hFE);
    bus("R4 R7 fetch match", 32'h1000, 32'h55, 8'h01, 1'b1);
    rd("R10 status u0", 5'h01, 32'h1);
    bus("R4 addr mismatch", 32'h1004, 32'h55, 8'h01, 1'b0);
    bus("R7 data access ignored by breakpoint", 32'h1000, 32'h55, 8'h00, 1'b0);
    rd("R10 sticky persists", 5'h01, 32'h1);
    clr_status();
    rd("R10 write-one clears", 5'h01, 32'h0);
    wr(5'h09, 32'h000000FF);
    bus("R5 masked low byte", 32'h10AB, 32'h0, 8'h01, 1'b1);
    bus("R5 unmasked bit differs", 32'h11AB, 32'h0, 8'h01, 1'b0);
    clr_status();
    prog(0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic t_data();
    prog(1, 32'h2000, 32'h0, 32'hDEADBEEF, 32'h0, 32'h102, 32'hFC);
    bus("R8 write match", 32'h2000, 32'hDEADBEEF, 8'h02, 1'b1);
    rd("R10 status u1", 5'h01, 32'h2);
    clr_status();
    bus("R8 read ignored by write watch", 32'h2000, 32'hDEADBEEF, 8'h00, 1'b0);
    bus("R4 data mismatch", 32'h2000, 32'hDEADBEEE, 8'h02, 1'b0);
    bus("R7 fetch ignored by data watch", 32'h2000, 32'hDEADBEEF, 8'h03, 1'b0);
    wr(5'h15, 32'hFE);
    bus("R8 either direction read", 32'h2000, 32'hDEADBEEF, 8'h00, 1'b1);
    bus("R8 either direction write", 32'h2000, 32'hDEADBEEF, 8'h02, 1'b1);
    clr_status();
  endtask

  task automatic t_enable();
    wr(5'h14, 32'h002);
    bus("R6 disabled unit", 32'h2000, 32'hDEADBEEF, 8'h02, 1'b0);
    rd("R6 no status", 5'h01, 32'h0);
    wr(5'h14, 32'h102);
    wr(5'h00, 32'h0);
    bus("R6 global disable", 32'h2000, 32'hDEADBEEF, 8'h02, 1'b0);
    rd("R6 no status global", 5'h01, 32'h0);
    wr(5'h00, 32'h1);
  endtask

  task automatic t_valid();
    @(negedge clk);
    bus_valid = 1'b0; bus_addr = 32'h2000; bus_data = 32'hDEADBEEF; bus_ctrl = 8'h02;
    @(negedge clk);
    check("R9 no valid no halt", 32'(halt_req), 32'h0);
    bus("R9 halt after valid", 32'h2000, 32'hDEADBEEF, 8'h02, 1'b1);
    @(negedge clk);
    check("R9 single cycle", 32'(halt_req), 32'h0);
    clr_status();
  endtask

  task automatic t_combine();
    prog(0, 32'h1000, 32'h0, 32'h0, 32'hFFFFFFFF, 32'h101, 32'hFE);
    prog(1, 32'h0, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h101, 32'hFE);
    wr(5'h00, 32'h3);
    bus("R11 both hit", 32'h1000, 32'h0, 8'h01, 1'b1);
    rd("R11 both status", 5'h01, 32'h3);
    clr_status();
    bus("R11 one hit no halt", 32'h3000, 32'h0, 8'h01, 1'b0);
    rd("R11 no status", 5'h01, 32'h0);
    wr(5'h00, 32'h1);
    bus("R11 independent halt", 32'h3000, 32'h0, 8'h01, 1'b1);
    rd("R11 own bit only", 5'h01, 32'h2);
    clr_status();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_unmapped();
    t_fetch();
    t_data();
    t_enable();
    t_valid();
    t_combine();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule